// File: doc/BRIEF.md
# DSP-mode serial audio receiver

This block deserialises a two-channel audio stream in which each sample period is marked by a short pulse on the frame-sync line rather than a half-duty left/right select. The serial data line is sampled on every rising edge of the bit clock. The edge on which the sync pulse is first seen high carries the most significant bit of the left word. The left word follows in the next 15 bits. The right word comes straight after it in the 16 bits that follow, with no gap. Any remaining bit slots before the next pulse are idle and are thrown away.

Once the 32nd bit is in, both parallel words are presented together and a one-cycle valid strobe is raised. A sync pulse that arrives before a frame is complete drops the partial frame and raises a framing-error flag. That same pulse starts a new frame. The flag stays up until a frame completes cleanly. The block runs entirely in the bit-clock domain and has a synchronous active-low reset.

Top module: `dsp_frame_rx`

## Requirements
- R1: A frame starts on a bit-clock rising edge where the sync input is high and it was low on the previous edge. The data bit sampled on that edge is bit 15 (the MSB) of the left word. A sync pulse that stays high for 1 to 4 edges starts exactly one frame.
- R2: The 32 data bits of a frame are assembled MSB first. Bits 1 to 16 form the left output and bits 17 to 32 form the right output. Both outputs change only in the cycle the valid strobe is high, and they hold their value at all other times.
- R3: The valid strobe is high for exactly one cycle. That cycle directly follows the rising edge that sampled the 32nd data bit.
- R4: Data bits after the 32nd, up to the next frame start, have no effect on any output. A frame that starts on the edge right after the 32nd bit of the previous frame (zero idle slots) is received correctly.
- R5: A frame start seen while 1 to 31 bits of a frame have been taken drops those bits, gives no valid strobe for them, and sets the framing-error flag in the cycle after that edge. The same edge supplies the left MSB of the new frame.
- R6: The framing-error flag stays high until the next frame completes. It is low in the cycle the valid strobe for that frame is high.
- R7: While the reset input is low at a clock edge, the outputs, the valid strobe and the error flag go to zero and no frame is in progress. Data bits before the first frame start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lrclk | input | 1 | Frame-sync pulse, high for 1 to 4 bit clocks at frame start |
| din | input | 1 | Serial audio data, MSB first |
| left_out | output | 16 | Last complete left-channel word |
| right_out | output | 16 | Last complete right-channel word |
| valid | output | 1 | One-cycle strobe when both words update |
| frame_err | output | 1 | Set by an aborted frame, cleared by the next complete one |

## Verification
Two functions can share a clock edge. One is the start of a new frame and the abort of an unfinished one, which the bench provokes by cutting frames short after 2, 10 and 31 bits. The other is the completion strobe of one frame and the first bit of the next, which the bench provokes by sending frames with no idle slots between them. In the first case, the error flag must rise one cycle after the pulse and the following frame must still decode from its own first bit. In the second case, the strobe must appear in exactly the cycle after the 32nd bit, and the next frame's words must arrive intact one frame later. A scoreboard queue checks this by matching each strobe against the frame that was pushed when its last bit was driven.

// File: rtl/dsp_rx_pkg.sv
// Package: shared sizing for the DSP-mode serial audio receiver.
// Assumes a fixed channel count of two (left word first, then right).
package dsp_rx_pkg;
    localparam int DEF_WORD_W = 16;
    localparam int NUM_CH     = 2;

    // Bits needed to hold a count from 0 to n inclusive.
    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/dsp_rx_sync.sv
// Module: frame-sync pulse detector.
// Flags the first bit-clock edge on which the sync line is seen high.
// Assumes the sync line is already in the bit-clock domain.
module dsp_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic frame_start
);
    logic sync_q;

    // Remember the sync level sampled at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_in;
    end

    // A start is a low-to-high step between two sampling edges.
    assign frame_start = sync_in & ~sync_q;
endmodule

// File: rtl/dsp_rx_deser.sv
// Module: frame bit counter and shift register.
// Counts the bits of a frame from its start edge and shifts them in.
// When the last bit arrives, it presents the whole frame word for one cycle.
// A start that cuts a frame short raises the abort output.
// Assumes frame_start comes from the sync detector in the same cycle.
module dsp_rx_deser #(
    parameter int FRAME_BITS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start,
    input  logic                  din,
    output logic                  frame_done,
    output logic [FRAME_BITS-1:0] frame_word,
    output logic                  frame_abort
);
    localparam int CNT_W = dsp_rx_pkg::cnt_bits(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);

    logic [CNT_W-1:0]      bit_cnt;   // 0: idle, n: n bits taken
    logic [FRAME_BITS-2:0] shreg;

    // Count the bits of a frame and shift them in; a start always restarts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (frame_start) begin
            bit_cnt <= CNT_W'(1);
            shreg   <= {shreg[FRAME_BITS-3:0], din};
        end else if (bit_cnt != '0) begin
            bit_cnt <= (bit_cnt == LAST_CNT) ? '0 : bit_cnt + CNT_W'(1);
            shreg   <= {shreg[FRAME_BITS-3:0], din};
        end
    end

    // The frame is complete on the edge that brings its last bit.
    assign frame_done  = !frame_start && (bit_cnt == LAST_CNT);
    assign frame_word  = {shreg, din};
    assign frame_abort = frame_start && (bit_cnt != '0);
endmodule

// File: rtl/dsp_rx_outreg.sv
// Module: output word registers, valid strobe and framing-error flag.
// Splits a finished frame into per-channel words, first channel in the upper bits.
// Assumes frame_done and frame_abort are never high together.
module dsp_rx_outreg #(
    parameter int WORD_W = 16,
    parameter int NUM_CH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_done,
    input  logic                     frame_abort,
    input  logic [NUM_CH*WORD_W-1:0] frame_word,
    output logic [WORD_W-1:0]        ch_word [NUM_CH],
    output logic                     valid,
    output logic                     frame_err
);
    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
            // Load this channel's slice of a completed frame.
            always_ff @(posedge clk) begin
                if (!rst_n)          ch_word[ch] <= '0;
                else if (frame_done) ch_word[ch] <= frame_word[(NUM_CH-1-ch)*WORD_W +: WORD_W];
            end
        end
    endgenerate

    // Pulse the strobe once per completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= frame_done;
    end

    // Set the error on an aborted frame; clear it on the next complete frame.
    always_ff @(posedge clk) begin
        if (!rst_n)           frame_err <= 1'b0;
        else if (frame_abort) frame_err <= 1'b1;
        else if (frame_done)  frame_err <= 1'b0;
    end
endmodule

// File: rtl/dsp_frame_rx.sv
// Module: top of the DSP-mode serial audio receiver.
// Takes a sync pulse, then 16 left bits and 16 right bits, MSB first.
// Presents both words with a one-cycle strobe per frame.
// Assumes all inputs are sampled on the rising bit-clock edge.
module dsp_frame_rx #(
    parameter int WORD_W = dsp_rx_pkg::DEF_WORD_W
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              lrclk,
    input  logic              din,
    output logic [WORD_W-1:0] left_out,
    output logic [WORD_W-1:0] right_out,
    output logic              valid,
    output logic              frame_err
);
    localparam int NUM_CH     = dsp_rx_pkg::NUM_CH;
    localparam int FRAME_BITS = NUM_CH * WORD_W;

    logic                  frame_start;
    logic                  frame_done;
    logic                  frame_abort;
    logic [FRAME_BITS-1:0] frame_word;
    logic [WORD_W-1:0]     ch_word [NUM_CH];

    dsp_rx_sync u_sync (
        .clk         (bclk),
        .rst_n       (rst_n),
        .sync_in     (lrclk),
        .frame_start (frame_start)
    );

    dsp_rx_deser #(.FRAME_BITS(FRAME_BITS)) u_deser (
        .clk         (bclk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .din         (din),
        .frame_done  (frame_done),
        .frame_word  (frame_word),
        .frame_abort (frame_abort)
    );

    dsp_rx_outreg #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_out (
        .clk         (bclk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .frame_abort (frame_abort),
        .frame_word  (frame_word),
        .ch_word     (ch_word),
        .valid       (valid),
        .frame_err   (frame_err)
    );

    assign left_out  = ch_word[0];
    assign right_out = ch_word[1];
endmodule

// File: rtl/dsp_frame_rx_chk.sv
// Module: property checker for the receiver, attached by bind.
// Assumes it observes the top ports and the internal start/abort nets.
module dsp_frame_rx_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              frame_abort,
    input logic [WORD_W-1:0] left_out,
    input logic [WORD_W-1:0] right_out,
    input logic              valid,
    input logic              frame_err
);
    // R3: the strobe never lasts two cycles.
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R2: the words hold whenever no strobe is shown.
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(left_out) && $stable(right_out)));

    // R5: an abort raises the error and gives no strobe.
    a_r5_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |=> (frame_err && !valid));

    // R6: a completed frame clears the error.
    a_r6_clear_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !frame_err);

    // R1: a start edge never completes a frame on the same edge.
    a_r1_start_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !valid);
endmodule

bind dsp_frame_rx dsp_frame_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (bclk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_abort (frame_abort),
    .left_out    (left_out),
    .right_out   (right_out),
    .valid       (valid),
    .frame_err   (frame_err)
);

// File: tb/tb_dsp_frame_rx.sv
module tb_dsp_frame_rx;
    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrclk = 1'b0;
    logic        din = 1'b0;
    logic [15:0] left_out, right_out;
    logic        valid, frame_err;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] exp_q [$];
    logic [15:0] hold_l = '0, hold_r = '0;
    logic        prev_valid = 1'b0;
    bit          finished = 1'b0;

    always #2 bclk = ~bclk;

    dsp_frame_rx dut (
        .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .din(din),
        .left_out(left_out), .right_out(right_out),
        .valid(valid), .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic s, input logic d);
        @(negedge bclk);
        lrclk = s;
        din   = d;
    endtask

    // Driver: sends one full frame and pushes the expected words when its last bit is driven.
    task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input int pulse,
                              input int idle, input logic exp_err);
        logic [31:0] w;
        w = {l, r};
        for (int i = 0; i < 32; i++) begin
            drive_bit(i < pulse, w[31-i]);
            if (i == 1)  check(frame_err == exp_err, "R5 error after start", 32'(frame_err), 32'(exp_err));
            if (i == 20) check(frame_err == exp_err, "R6 error held", 32'(frame_err), 32'(exp_err));
            if (i == 31) exp_q.push_back(w);
        end
        for (int j = 0; j < idle; j++) drive_bit(1'b0, j[0] ^ j[2]);
    endtask

    // Driver: sends a frame cut short after nbits bits (no expected item).
    task automatic send_partial(input int nbits, input int pulse);
        for (int i = 0; i < nbits; i++) drive_bit(i < pulse, i[0] | i[1]);
    endtask

    // Monitor: compares each strobe against the scoreboard, checks timing and holding.
    initial begin
        forever begin
            @(posedge bclk);
            #1;
            if (rst_n && !finished) begin
                if (valid) begin
                    if (prev_valid) check(1'b0, "R3 strobe longer than one cycle", 32'(valid), 32'(0));
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4 unexpected strobe", 32'(valid), 32'(0));
                    end else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        check(left_out  == e[31:16], "R2 left word",  32'(left_out),  32'(e[31:16]));
                        check(right_out == e[15:0],  "R2 right word", 32'(right_out), 32'(e[15:0]));
                        check(frame_err == 1'b0, "R6 error clear on strobe", 32'(frame_err), 32'(0));
                    end
                    hold_l = left_out;
                    hold_r = right_out;
                end else begin
                    if (exp_q.size() != 0) begin
                        check(1'b0, "R3 strobe missing", 32'(valid), 32'(1));
                        void'(exp_q.pop_front());
                    end
                    if (left_out != hold_l || right_out != hold_r)
                        check(1'b0, "R2 words changed without strobe",
                              {left_out, right_out}, {hold_l, hold_r});
                end
                prev_valid = valid;
            end
        end
    end

    // Watchdog.
    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog expired", 32'(0), 32'(1));
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge bclk);
        check(left_out == 16'h0,  "R7 reset left",  32'(left_out),  32'(0));
        check(right_out == 16'h0, "R7 reset right", 32'(right_out), 32'(0));
        check(valid == 1'b0 && frame_err == 1'b0, "R7 reset flags", {valid, frame_err}, 32'(0));
        rst_n = 1'b1;
        // R7: data before the first sync pulse is ignored (monitor flags any strobe).
        for (int i = 0; i < 40; i++) drive_bit(1'b0, i[0]);
        send_frame(16'h1234, 16'hABCD, 1, 5, 1'b0);   // R1 one-edge pulse
        send_frame(16'hFFFF, 16'h0000, 4, 0, 1'b0);   // R1 four-edge pulse, R4 no idle slots
        send_frame(16'h8001, 16'h7FFE, 2, 0, 1'b0);   // R4 back to back
        send_frame(16'hA5A5, 16'h5A5A, 3, 20, 1'b0);  // R4 long toggling idle
        send_partial(10, 1);                          // R5 abort mid left word
        send_frame(16'h0F0F, 16'hF0F0, 1, 3, 1'b1);
        send_partial(31, 2);                          // R5 abort one bit short
        send_frame(16'h0001, 16'h8000, 2, 0, 1'b1);
        send_partial(2, 1);                           // R5 abort right after start
        send_frame(16'hC3C3, 16'h3C3C, 1, 7, 1'b0 | 1'b1);
        send_frame(16'h0000, 16'hFFFF, 4, 12, 1'b0);
        for (int i = 0; i < 10; i++) drive_bit(1'b0, 1'b1);
        check(exp_q.size() == 0, "R3 all frames strobed", 32'(exp_q.size()), 32'(0));
        check(valid == 1'b0 && frame_err == 1'b0, "R4 idle after last frame",
              {valid, frame_err}, 32'(0));
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule